// File: doc/BRIEF.md
# Dual-Thread Partitioned Issue Queue

This block is a first-in first-out buffer shared by two hardware threads. It sits between an instruction front end, which pushes work for either thread, and an execution back end, which drains it. The two sides are decoupled: a push and a pop can complete in the same cycle without interfering with each other. Each entry belongs to one thread, and each thread's entries leave in the order they arrived.

A four-state mode controller watches per-thread halt and wake requests and sets how much of the capacity each thread may use. When both threads run, each is capped at half the entries. When one thread halts, the survivor may use all of them. When both have halted, the block reports a low-power state. When both threads hold entries, the pop side alternates between them, one pop per cycle.

Top module: `split_uop_queue`

## Requirements
- R1: In mode MT (code 0) a thread whose occupancy has reached DEPTH/2 (8 by default) sees its push_ready low, and its occupancy never grows beyond that.
- R2: The mode output uses the codes MT=0, ST0=1 (only thread 0 active), ST1=2 (only thread 1 active), LP=3. In MT, a halt from thread 0 alone (halt_req=2'b01) gives ST1 on the next cycle, a halt from thread 1 alone gives ST0, and halts from both give LP. Wake requests are ignored in MT.
- R3: In ST0 or ST1 the active thread may fill all DEPTH entries, and the total stored never exceeds DEPTH.
- R4: In a single-thread mode, a wake of the halted thread returns the block to MT on the next cycle. Failing that, a halt of the active thread enters LP, where low_power is 1 and low_power is 0 in every other mode.
- R5: In LP, a wake of thread 0 alone gives ST0, a wake of thread 1 alone gives ST1, and a wake of both gives MT.
- R6: A halted thread's push_ready is 0 and its push_valid is ignored: nothing of its data appears on its pop port.
- R7: Each thread's entries come out in push order, and a push and a pop on the same thread in one cycle both take effect.
- R8: Pop side: at most one pop_valid bit is high per cycle. When both threads hold entries, the served thread alternates after every completed pop, with thread 0 served first after reset. With one thread holding entries, its pop_valid is high. An entry pushed into an empty thread queue becomes visible on the cycle after the push.
- R9: On a return to MT with the active thread holding more than DEPTH/2 entries, its push_ready stays 0 until its occupancy falls below DEPTH/2.
- R10: A synchronous active-high reset empties the queue, sets mode MT and low_power to 0, and gives push_ready=2'b11 and pop_valid=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 2 | Per-thread halt request, bit t for thread t |
| wake_req | input | 2 | Per-thread wake request, bit t for thread t |
| push_valid | input | 2 | Per-thread push request |
| push_ready | output | 2 | Per-thread push acceptance |
| push_data0 | input | DATA_W | Entry pushed by thread 0 |
| push_data1 | input | DATA_W | Entry pushed by thread 1 |
| pop_valid | output | 2 | Per-thread head entry offered |
| pop_ready | input | 2 | Per-thread back-end acceptance |
| pop_data0 | output | DATA_W | Head entry of thread 0 |
| pop_data1 | output | DATA_W | Head entry of thread 1 |
| mode | output | 2 | Current mode code |
| low_power | output | 1 | High in LP mode |

## Verification
A wrong mode state shows up one cycle after the offending halt or wake, both on the mode code and on push_ready. The push_ready bits carry the active-thread mask while the queue is empty. A miscounted occupancy first shows as push_ready dropping too early or too late at the half or full boundary, and a stale or misordered pointer shows as a wrong value on the pop data port at the next pop of that thread. A broken round-robin pointer shows within two pops while both threads hold entries.

// File: rtl/suq_pkg.sv
package suq_pkg;

  typedef enum logic [1:0] {
    MODE_MT  = 2'd0,
    MODE_ST0 = 2'd1,
    MODE_ST1 = 2'd2,
    MODE_LP  = 2'd3
  } suq_mode_e;

  // Which threads may push in a given mode.
  function automatic logic [1:0] active_mask(input suq_mode_e m);
    case (m)
      MODE_MT:  return 2'b11;
      MODE_ST0: return 2'b01;
      MODE_ST1: return 2'b10;
      default:  return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/suq_mode_ctrl.sv
module suq_mode_ctrl
  import suq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] halt_req,
  input  logic [1:0] wake_req,
  output suq_mode_e  mode,
  output logic [1:0] active
);

  suq_mode_e mode_q, mode_d;

  function automatic suq_mode_e next_mode(input suq_mode_e cur,
                                          input logic [1:0] h,
                                          input logic [1:0] w);
    suq_mode_e n;
    n = cur;
    case (cur)
      MODE_MT: begin
        if (h == 2'b11)   n = MODE_LP;
        else if (h[0])    n = MODE_ST1;
        else if (h[1])    n = MODE_ST0;
      end
      MODE_ST0: begin
        if (w[1])         n = MODE_MT;
        else if (h[0])    n = MODE_LP;
      end
      MODE_ST1: begin
        if (w[0])         n = MODE_MT;
        else if (h[1])    n = MODE_LP;
      end
      default: begin
        if (w == 2'b11)   n = MODE_MT;
        else if (w[0])    n = MODE_ST0;
        else if (w[1])    n = MODE_ST1;
      end
    endcase
    return n;
  endfunction

  always_comb mode_d = next_mode(mode_q, halt_req, wake_req);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_MT;
    else     mode_q <= mode_d;
  end

  assign mode   = mode_q;
  assign active = active_mask(mode_q);

  AST_T0_HALT_TO_ST1: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_MT && halt_req == 2'b01) |=> mode_q == MODE_ST1); // R2
  AST_T1_HALT_TO_ST0: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_MT && halt_req == 2'b10) |=> mode_q == MODE_ST0); // R2
  AST_LAST_HALT_TO_LP: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_ST0 && halt_req[0] && !wake_req[1]) |=> mode_q == MODE_LP); // R4
  AST_LP_WAKE_LEAVES: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LP && wake_req != 2'b00) |=> mode_q != MODE_LP); // R5

endmodule

// File: rtl/suq_thread_fifo.sv
module suq_thread_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [CW-1:0]     count
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q < FULL || pop)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt_q != '0); // R7

endmodule

// File: rtl/suq_pop_arb.sv
module suq_pop_arb (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] nonempty,
  input  logic [1:0] pop_ready,
  output logic [1:0] pop_valid,
  output logic [1:0] pop_fire
);

  logic rr_q;   // thread favoured when both hold entries

  function automatic logic [1:0] offer(input logic [1:0] ne, input logic pref);
    if (ne == 2'b11) return pref ? 2'b10 : 2'b01;
    return ne;
  endfunction

  assign pop_valid = offer(nonempty, rr_q);
  assign pop_fire  = pop_valid & pop_ready;

  always_ff @(posedge clk) begin
    if (rst)              rr_q <= 1'b0;
    else if (pop_fire[0]) rr_q <= 1'b1;
    else if (pop_fire[1]) rr_q <= 1'b0;
  end

  AST_SINGLE_OFFER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop_valid)); // R8
  AST_RR_SWITCH_T1: assert property (@(posedge clk) disable iff (rst)
    (pop_fire[0] && nonempty[1]) |=> pop_valid[1]); // R8
  AST_RR_SWITCH_T0: assert property (@(posedge clk) disable iff (rst)
    (pop_fire[1] && nonempty[0]) |=> pop_valid[0]); // R8

endmodule

// File: rtl/split_uop_queue.sv
module split_uop_queue
  import suq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        halt_req,
  input  logic [1:0]        wake_req,
  input  logic [1:0]        push_valid,
  output logic [1:0]        push_ready,
  input  logic [DATA_W-1:0] push_data0,
  input  logic [DATA_W-1:0] push_data1,
  output logic [1:0]        pop_valid,
  input  logic [1:0]        pop_ready,
  output logic [DATA_W-1:0] pop_data0,
  output logic [DATA_W-1:0] pop_data1,
  output logic [1:0]        mode,
  output logic              low_power
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  suq_mode_e         cur_mode;
  logic [1:0]        active;
  logic [CW-1:0]     occ     [2];
  logic [DATA_W-1:0] din_t   [2];
  logic [DATA_W-1:0] dout_t  [2];
  logic [1:0]        push_fire, pop_fire, nonempty;
  logic [CW:0]       total;
  logic [CW-1:0]     thread_cap;

  // Per-thread cap: half the depth while both run, the whole depth otherwise.
  function automatic logic [CW-1:0] cap_for(input suq_mode_e m);
    return (m == MODE_MT) ? HALF_C : FULL_C;
  endfunction

  function automatic logic [CW:0] sum_occ(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  suq_mode_ctrl u_mode (
    .clk      (clk),
    .rst      (rst),
    .halt_req (halt_req),
    .wake_req (wake_req),
    .mode     (cur_mode),
    .active   (active)
  );

  assign din_t[0]   = push_data0;
  assign din_t[1]   = push_data1;
  assign thread_cap = cap_for(cur_mode);
  assign total      = sum_occ(occ[0], occ[1]);

  for (genvar t = 0; t < 2; t++) begin : g_thread
    assign push_ready[t] = active[t] && (occ[t] < thread_cap) && (total < {1'b0, FULL_C});
    assign push_fire[t]  = push_valid[t] && push_ready[t];
    assign nonempty[t]   = (occ[t] != '0);

    suq_thread_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (push_fire[t]),
      .din   (din_t[t]),
      .pop   (pop_fire[t]),
      .dout  (dout_t[t]),
      .count (occ[t])
    );

    AST_MT_HALF_CAP: assert property (@(posedge clk) disable iff (rst)
      (cur_mode == MODE_MT && occ[t] >= HALF_C) |=> occ[t] <= $past(occ[t])); // R1
    AST_HALTED_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
      !active[t] |=> occ[t] <= $past(occ[t])); // R6
  end

  suq_pop_arb u_arb (
    .clk       (clk),
    .rst       (rst),
    .nonempty  (nonempty),
    .pop_ready (pop_ready),
    .pop_valid (pop_valid),
    .pop_fire  (pop_fire)
  );

  assign pop_data0 = dout_t[0];
  assign pop_data1 = dout_t[1];
  assign mode      = cur_mode;
  assign low_power = (cur_mode == MODE_LP);

  AST_TOTAL_CAP: assert property (@(posedge clk) disable iff (rst)
    total <= {1'b0, FULL_C}); // R3
  AST_LP_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    low_power |-> push_ready == 2'b00); // R4

endmodule

// File: tb/split_uop_queue_test.sv
module split_uop_queue_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 32;
  localparam int HALF   = DEPTH / 2;

  // {halt[1:0], wake[1:0], expected mode[1:0], expected push_ready[1:0]}
  localparam int NVEC = 12;
  localparam logic [7:0] MODE_VEC [NVEC] = '{
    8'b01_00_10_10,  // MT  -> ST1 (thread 0 halts)
    8'b00_00_10_10,  // ST1 holds
    8'b00_01_00_11,  // ST1 -> MT  (thread 0 wakes)
    8'b10_00_01_01,  // MT  -> ST0 (thread 1 halts)
    8'b01_00_11_00,  // ST0 -> LP  (thread 0 halts)
    8'b00_10_10_10,  // LP  -> ST1
    8'b10_00_11_00,  // ST1 -> LP
    8'b00_01_01_01,  // LP  -> ST0
    8'b00_10_00_11,  // ST0 -> MT
    8'b11_00_11_00,  // MT  -> LP  (both halt)
    8'b00_11_00_11,  // LP  -> MT  (both wake)
    8'b00_11_00_11   // wake ignored in MT
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        halt_req = '0, wake_req = '0, push_valid = '0, pop_ready = '0;
  logic [DATA_W-1:0] push_data0 = '0, push_data1 = '0;
  logic [1:0]        push_ready, pop_valid, mode;
  logic [DATA_W-1:0] pop_data0, pop_data1;
  logic              low_power;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  split_uop_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .wake_req(wake_req),
    .push_valid(push_valid), .push_ready(push_ready),
    .push_data0(push_data0), .push_data1(push_data1),
    .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_data0(pop_data0), .pop_data1(pop_data1),
    .mode(mode), .low_power(low_power)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R10 mode", 32'(mode), 32'd0);
    check("R10 low_power", 32'(low_power), 32'd0);
    check("R10 push_ready", 32'(push_ready), 32'b11);
    check("R10 pop_valid", 32'(pop_valid), 32'b00);
    @(negedge clk);

    // Mode table: R2, R4, R5, R6 (push_ready mirrors the active mask while empty)
    for (int i = 0; i < NVEC; i++) begin
      halt_req = MODE_VEC[i][7:6];
      wake_req = MODE_VEC[i][5:4];
      @(negedge clk);
      halt_req = '0;
      wake_req = '0;
      #1;
      check($sformatf("R2/R4/R5 mode vec%0d", i), 32'(mode), 32'(MODE_VEC[i][3:2]));
      check($sformatf("R4 low_power vec%0d", i), 32'(low_power),
            32'(MODE_VEC[i][3:2] == 2'd3));
      check($sformatf("R6 push_ready vec%0d", i), 32'(push_ready), 32'(MODE_VEC[i][1:0]));
    end

    // R1: fill thread 0 to the half cap in MT, thread 1 with four entries
    for (int i = 0; i < HALF; i++) begin
      push_valid = {(i < 4), 1'b1};
      push_data0 = 32'(100 + i);
      push_data1 = 32'(200 + i);
      #1;
      check("R1 push_ready t0 below half", 32'(push_ready[0]), 32'd1);
      @(negedge clk);
    end
    push_valid = '0;
    #1;
    check("R1 push_ready at half", 32'(push_ready), 32'b10);

    // R8 / R7: alternating drain, per-thread order
    pop_ready = 2'b11;
    for (int k = 0, n0 = 0, n1 = 0; k < 12; k++) begin
      #1;
      if (k < 8 && (k % 2) == 1) begin
        check("R8 pop_valid alt t1", 32'(pop_valid), 32'b10);
        check("R7 pop_data1 order", pop_data1, 32'(200 + n1));
        n1++;
      end else begin
        check("R8 pop_valid t0", 32'(pop_valid), 32'b01);
        check("R7 pop_data0 order", pop_data0, 32'(100 + n0));
        n0++;
      end
      @(negedge clk);
    end
    pop_ready = '0;
    #1;
    check("R8 pop_valid empty", 32'(pop_valid), 32'b00);

    // R7 / R8: push into empty, then push and pop in the same cycle
    @(negedge clk);
    push_valid = 2'b01;
    push_data0 = 32'hA0;
    #1;
    check("R8 not visible same cycle", 32'(pop_valid), 32'b00);
    @(negedge clk);
    push_data0 = 32'hB0;
    pop_ready  = 2'b01;
    #1;
    check("R8 visible next cycle", 32'(pop_valid), 32'b01);
    check("R7 head A", pop_data0, 32'hA0);
    @(negedge clk);
    push_valid = '0;
    #1;
    check("R7 same-cycle push kept", 32'(pop_valid), 32'b01);
    check("R7 head B", pop_data0, 32'hB0);
    @(negedge clk);
    pop_ready = '0;
    #1;
    check("R7 drained", 32'(pop_valid), 32'b00);

    // R3 / R6: ST0, thread 0 fills the whole queue, thread 1 pushes ignored
    halt_req = 2'b10;
    @(negedge clk);
    halt_req = '0;
    #1;
    check("R2 mode ST0", 32'(mode), 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      push_valid = 2'b11;
      push_data0 = 32'(300 + i);
      push_data1 = 32'hDEAD;
      #1;
      check("R3 push_ready t0 in ST0", 32'(push_ready[0]), 32'd1);
      check("R6 push_ready halted t1", 32'(push_ready[1]), 32'd0);
      @(negedge clk);
    end
    push_valid = '0;
    #1;
    check("R3 full after DEPTH", 32'(push_ready[0]), 32'd0);
    check("R6 halted pushes absent", 32'(pop_valid), 32'b01);

    // R9: wake thread 1, thread 0 over the half limit
    wake_req = 2'b10;
    @(negedge clk);
    wake_req = '0;
    #1;
    check("R4 mode back to MT", 32'(mode), 32'd0);
    pop_ready = 2'b01;
    for (int n = 0; n < DEPTH; n++) begin
      #1;
      check("R9 push_ready t0 while draining", 32'(push_ready[0]), 32'((DEPTH - n) < HALF));
      check("R3 data order", pop_data0, 32'(300 + n));
      check("R6 no t1 entry", 32'(pop_valid[1]), 32'd0);
      @(negedge clk);
    end
    pop_ready = '0;
    #1;
    check("R10 empty again", 32'(pop_valid), 32'b00);

    done = 1;
    finish_run();
  end

endmodule